// File: doc/BRIEF.md
# Interrupt Request and Vector Sequencer

This block sits beside the main instruction sequencer of an 8-bit processor with a 16-bit address bus. It watches the reset, non-maskable, fast and normal interrupt requests and the two mask bits of the condition code register. At an instruction boundary it decides which request to service. It then hands the main sequencer a one-cycle grant. The grant carries a 3-bit vector code, the address of the vector's high byte, the mask bits to set, and a flag that says whether every register or only the return address and condition codes go on the stack.

The block also covers two related cases. When the wait-for-interrupt instruction is executing, the block either grants the request or signals that execution simply resumes. On a return from interrupt, it captures the full-restore decision from the condition code byte that was just pulled from the stack. When the main sequencer lands in its error state, the block answers with a one-cycle order to run a return-from-interrupt sequence. A hold input freezes all state.

Top module: `int_seq_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `take` pulses with `vec_code` = 3'b111, `vec_addr` = 16'hFFFE, `entire` = 0 and both `set_i` and `set_f` = 1. `take` stays 0 while reset is held.
- R2: At an instruction boundary, priority is non-maskable (code 3'b110), then fast (3'b011), then normal (3'b100).
- R3: The fast request is blocked while `mask_f` = 1, and the normal request is blocked while `mask_i` = 1.
- R4: Non-maskable edges that occur before the first `sp_loaded` pulse after reset are ignored and are not remembered.
- R5: A rising edge on `nmi_in` is latched, so a one-cycle pulse is enough, and it stays pending until granted. A level held high does not request again.
- R6: `entire` is 1 for non-maskable and normal grants, and 0 for fast and reset grants. It is valid from the grant cycle onwards.
- R7: A non-maskable or fast grant sets both `set_i` and `set_f`. A normal grant sets `set_i` only.
- R8: `vec_addr` equals 16'hFFF0 plus twice `vec_code`, and points at the high byte of the vector.
- R9: Once `sync_req` has been seen, the block waits. An unmasked request is then granted. If only masked requests are present, `sync_resume` pulses for one cycle with no grant.
- R10: One cycle after `rti_pull`, `rti_full` equals the `rti_e` value presented with it. It holds that value until the next `rti_pull`.
- R11: `bogus` gives a one-cycle `rti_go` pulse in the following cycle.
- R12: While `hold` = 1, every output and all internal state keep their values.
- R13: After a grant, no further grant is given until `done` has been seen. In normal running, no grant is given without `boundary`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freeze all state |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| firq_in | input | 1 | Fast request, level |
| irq_in | input | 1 | Normal request, level |
| mask_f | input | 1 | Fast-request mask bit from the condition codes |
| mask_i | input | 1 | Normal-request mask bit from the condition codes |
| sp_loaded | input | 1 | Strobe: system stack pointer written |
| boundary | input | 1 | Main sequencer is at an instruction boundary |
| sync_req | input | 1 | Wait-for-interrupt instruction is executing |
| done | input | 1 | Main sequencer has finished the granted sequence |
| rti_pull | input | 1 | Strobe: condition codes have been pulled on return |
| rti_e | input | 1 | Entire-state bit of the pulled condition codes |
| bogus | input | 1 | Main sequencer entered its error state |
| take | output | 1 | One-cycle grant |
| vec_code | output | 3 | Vector code of the grant |
| vec_addr | output | 16 | Address of the vector's high byte |
| entire | output | 1 | Stack every register (1) or only return address and condition codes (0) |
| set_i | output | 1 | Set the normal mask on entry |
| set_f | output | 1 | Set the fast mask on entry |
| sync_resume | output | 1 | Wait ended by a masked request; continue with the next instruction |
| rti_full | output | 1 | Restore every register on return |
| rti_go | output | 1 | Run a return-from-interrupt sequence |

## Verification
Several rules are checked by the assertions on every cycle:
- no back-to-back grants;
- a fast or normal grant only when the matching request was present and unmasked;
- no non-maskable grant before the stack pointer has been loaded;
- fast grants that never ask for the full register set;
- the freeze under hold;
- the capture of the pulled entire bit;
- the error-state answer.

Other behaviour can only be shown by the bench's scenarios:
- the priority order when several requests arrive together;
- forgetting an early non-maskable edge;
- a held non-maskable level that does not request again;
- the two outcomes of the wait instruction.

A cycle-level reference model compares every output on every clock.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

    typedef enum logic [1:0] {
        SQ_RESET = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_SYNC  = 2'd2,
        SQ_BUSY  = 2'd3
    } seq_state_e;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] VC_RESET = 3'b111;
    localparam logic [CODE_W-1:0] VC_NMI   = 3'b110;
    localparam logic [CODE_W-1:0] VC_SWI   = 3'b101;
    localparam logic [CODE_W-1:0] VC_IRQ   = 3'b100;
    localparam logic [CODE_W-1:0] VC_FIRQ  = 3'b011;
    localparam logic [CODE_W-1:0] VC_SWI2  = 3'b010;
    localparam logic [CODE_W-1:0] VC_SWI3  = 3'b001;
    localparam logic [CODE_W-1:0] VC_RSVD  = 3'b000;

    typedef struct packed {
        seq_state_e        st;
        logic              take;
        logic [CODE_W-1:0] code;
        logic              entire;
        logic              set_i;
        logic              set_f;
        logic              resume;
        logic              rti_full;
        logic              rti_go;
    } seq_regs_t;

endpackage

// File: rtl/int_seq_nmi.sv
module int_seq_nmi (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic nmi_in,
    input  logic sp_loaded,
    input  logic clr,
    output logic pend
);
    logic arm_q, arm_d;
    logic prev_q, prev_d;
    logic pend_q, pend_d;

    always_comb begin
        arm_d  = arm_q | sp_loaded;
        prev_d = nmi_in;
        pend_d = pend_q & ~clr;
        if (arm_q && nmi_in && !prev_q) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!hold) begin
            arm_q  <= arm_d;
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/int_seq_pick.sv
module int_seq_pick
    import int_seq_pkg::*;
(
    input  logic              nmi_pend,
    input  logic              firq_in,
    input  logic              irq_in,
    input  logic              mask_f,
    input  logic              mask_i,
    output logic              hit,
    output logic              any_req,
    output logic [CODE_W-1:0] code,
    output logic              entire,
    output logic              set_i,
    output logic              set_f
);
    always_comb begin
        hit    = 1'b0;
        code   = VC_RSVD;
        entire = 1'b0;
        set_i  = 1'b0;
        set_f  = 1'b0;
        if (nmi_pend) begin
            hit    = 1'b1;
            code   = VC_NMI;
            entire = 1'b1;
            set_i  = 1'b1;
            set_f  = 1'b1;
        end else if (firq_in && !mask_f) begin
            hit    = 1'b1;
            code   = VC_FIRQ;
            entire = 1'b0;
            set_i  = 1'b1;
            set_f  = 1'b1;
        end else if (irq_in && !mask_i) begin
            hit    = 1'b1;
            code   = VC_IRQ;
            entire = 1'b1;
            set_i  = 1'b1;
            set_f  = 1'b0;
        end
    end

    assign any_req = nmi_pend | firq_in | irq_in;
endmodule

// File: rtl/int_seq_ctrl.sv
module int_seq_ctrl
    import int_seq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_BASE = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              nmi_in,
    input  logic              firq_in,
    input  logic              irq_in,
    input  logic              mask_f,
    input  logic              mask_i,
    input  logic              sp_loaded,
    input  logic              boundary,
    input  logic              sync_req,
    input  logic              done,
    input  logic              rti_pull,
    input  logic              rti_e,
    input  logic              bogus,
    output logic              take,
    output logic [2:0]        vec_code,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              entire,
    output logic              set_i,
    output logic              set_f,
    output logic              sync_resume,
    output logic              rti_full,
    output logic              rti_go
);
    localparam logic [ADDR_W-1:0] BASE_A = VEC_BASE[ADDR_W-1:0];

    seq_regs_t q, d;

    logic              nmi_pend, nmi_clr;
    logic              p_hit, p_any, p_ent, p_si, p_sf;
    logic [CODE_W-1:0] p_code;

    int_seq_nmi u_nmi (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .nmi_in    (nmi_in),
        .sp_loaded (sp_loaded),
        .clr       (nmi_clr),
        .pend      (nmi_pend)
    );

    int_seq_pick u_pick (
        .nmi_pend (nmi_pend),
        .firq_in  (firq_in),
        .irq_in   (irq_in),
        .mask_f   (mask_f),
        .mask_i   (mask_i),
        .hit      (p_hit),
        .any_req  (p_any),
        .code     (p_code),
        .entire   (p_ent),
        .set_i    (p_si),
        .set_f    (p_sf)
    );

    always_comb begin
        logic grant;
        d        = q;
        d.take   = 1'b0;
        d.resume = 1'b0;
        d.rti_go = bogus;
        grant    = 1'b0;
        if (rti_pull) begin
            d.rti_full = rti_e;
        end
        case (q.st)
            SQ_RESET: begin
                d.take   = 1'b1;
                d.code   = VC_RESET;
                d.entire = 1'b0;
                d.set_i  = 1'b1;
                d.set_f  = 1'b1;
                d.st     = SQ_BUSY;
            end
            SQ_RUN: begin
                if (boundary && p_hit) begin
                    grant = 1'b1;
                end else if (sync_req) begin
                    d.st = SQ_SYNC;
                end
            end
            SQ_SYNC: begin
                if (p_hit) begin
                    grant = 1'b1;
                end else if (p_any) begin
                    d.resume = 1'b1;
                    d.st     = SQ_RUN;
                end
            end
            default: begin
                if (done) begin
                    d.st = SQ_RUN;
                end
            end
        endcase
        if (grant) begin
            d.take   = 1'b1;
            d.code   = p_code;
            d.entire = p_ent;
            d.set_i  = p_si;
            d.set_f  = p_sf;
            d.st     = SQ_BUSY;
        end
        nmi_clr = grant && (p_code == VC_NMI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st       <= SQ_RESET;
            q.take     <= 1'b0;
            q.code     <= VC_RESET;
            q.entire   <= 1'b0;
            q.set_i    <= 1'b1;
            q.set_f    <= 1'b1;
            q.resume   <= 1'b0;
            q.rti_full <= 1'b0;
            q.rti_go   <= 1'b0;
        end else if (!hold) begin
            q <= d;
        end
    end

    assign take        = q.take;
    assign vec_code    = q.code;
    assign vec_addr    = BASE_A + ({{(ADDR_W-CODE_W){1'b0}}, q.code} << 1);
    assign entire      = q.entire;
    assign set_i       = q.set_i;
    assign set_f       = q.set_f;
    assign sync_resume = q.resume;
    assign rti_full    = q.rti_full;
    assign rti_go      = q.rti_go;
endmodule

// File: rtl/int_seq_ctrl_chk.sv
module int_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       hold,
    input logic       firq_in,
    input logic       irq_in,
    input logic       mask_f,
    input logic       mask_i,
    input logic       sp_loaded,
    input logic       rti_pull,
    input logic       rti_e,
    input logic       bogus,
    input logic       take,
    input logic [2:0] vec_code,
    input logic       entire,
    input logic       sync_resume,
    input logic       rti_full,
    input logic       rti_go
);
    logic seen_sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sp_q <= 1'b0;
        end else if (sp_loaded && !hold) begin
            seen_sp_q <= 1'b1;
        end
    end

    assert_no_double_take_R13: assert property (@(posedge clk) disable iff (rst)
        (take && !hold) |=> !take);

    assert_firq_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !$past(hold) && vec_code == 3'b011) |-> $past(firq_in && !mask_f));

    assert_irq_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !$past(hold) && vec_code == 3'b100) |-> $past(irq_in && !mask_i));

    assert_nmi_after_sp_R4: assert property (@(posedge clk) disable iff (rst)
        (take && vec_code == 3'b110) |-> seen_sp_q);

    assert_firq_partial_R6: assert property (@(posedge clk) disable iff (rst)
        (take && vec_code == 3'b011) |-> !entire);

    assert_resume_no_take_R9: assert property (@(posedge clk) disable iff (rst)
        sync_resume |-> !take);

    assert_rti_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (rti_pull && !hold) |=> (rti_full == $past(rti_e)));

    assert_bogus_rti_R11: assert property (@(posedge clk) disable iff (rst)
        (bogus && !hold) |=> rti_go);

    assert_hold_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(take) && $stable(vec_code) && $stable(entire) && $stable(rti_full)));
endmodule

bind int_seq_ctrl int_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .firq_in     (firq_in),
    .irq_in      (irq_in),
    .mask_f      (mask_f),
    .mask_i      (mask_i),
    .sp_loaded   (sp_loaded),
    .rti_pull    (rti_pull),
    .rti_e       (rti_e),
    .bogus       (bogus),
    .take        (take),
    .vec_code    (vec_code),
    .entire      (entire),
    .sync_resume (sync_resume),
    .rti_full    (rti_full),
    .rti_go      (rti_go)
);

// File: tb/sim_int_seq_ctrl.sv
`timescale 1ns/1ps
module sim_int_seq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1, hold = 1'b0, nmi_in = 1'b0, firq_in = 1'b0, irq_in = 1'b0;
    logic mask_f = 1'b0, mask_i = 1'b0, sp_loaded = 1'b0, boundary = 1'b0;
    logic sync_req = 1'b0, done = 1'b0, rti_pull = 1'b0, rti_e = 1'b0, bogus = 1'b0;
    logic take, entire, set_i, set_f, sync_resume, rti_full, rti_go;
    logic [2:0]  vec_code;
    logic [15:0] vec_addr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    int_seq_ctrl u0 (
        .clk(clk), .rst(rst), .hold(hold), .nmi_in(nmi_in), .firq_in(firq_in),
        .irq_in(irq_in), .mask_f(mask_f), .mask_i(mask_i), .sp_loaded(sp_loaded),
        .boundary(boundary), .sync_req(sync_req), .done(done), .rti_pull(rti_pull),
        .rti_e(rti_e), .bogus(bogus), .take(take), .vec_code(vec_code),
        .vec_addr(vec_addr), .entire(entire), .set_i(set_i), .set_f(set_f),
        .sync_resume(sync_resume), .rti_full(rti_full), .rti_go(rti_go)
    );

    // behavioural reference model: mode 0 start, 1 running, 2 waiting, 3 serving
    int m_mode = 0;
    bit m_armed = 0, m_last = 0, m_nmi = 0;
    bit m_take = 0, m_ent = 0, m_si = 1, m_sf = 1, m_res = 0, m_rf = 0, m_rg = 0;
    int m_code = 7;

    function automatic int pick(input bit n, input bit f, input bit i, input bit mf, input bit mi);
        if (n) return 6;
        if (f && !mf) return 3;
        if (i && !mi) return 4;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_armed = 0; m_last = 0; m_nmi = 0; m_take = 0; m_code = 7;
            m_ent = 0; m_si = 1; m_sf = 1; m_res = 0; m_rf = 0; m_rg = 0;
        end else if (!hold) begin
            int w;
            bit granted;
            bit edge_seen;
            granted = 0;
            edge_seen = m_armed && nmi_in && !m_last;
            w = pick(m_nmi, firq_in, irq_in, mask_f, mask_i);
            m_take = 0; m_res = 0; m_rg = bogus;
            if (rti_pull) m_rf = rti_e;
            if (m_mode == 0) begin
                m_take = 1; m_code = 7; m_ent = 0; m_si = 1; m_sf = 1; m_mode = 3;
            end else if (m_mode == 1) begin
                if (boundary && w >= 0) granted = 1;
                else if (sync_req) m_mode = 2;
            end else if (m_mode == 2) begin
                if (w >= 0) granted = 1;
                else if (m_nmi || firq_in || irq_in) begin m_res = 1; m_mode = 1; end
            end else if (done) m_mode = 1;
            if (granted) begin
                m_take = 1; m_code = w; m_mode = 3;
                m_ent = (w != 3); m_si = 1; m_sf = (w != 4);
                if (w == 6) m_nmi = 0;
            end
            if (edge_seen) m_nmi = 1;
            m_last = nmi_in;
            if (sp_loaded) m_armed = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic compare_model();
        chk(take == m_take, "R13 take vs model", take, m_take);
        chk(vec_code == m_code[2:0], "R2 code vs model", vec_code, m_code);
        chk(vec_addr == 16'hFFF0 + 16'(m_code * 2), "R8 address vs model", vec_addr, 16'hFFF0 + m_code * 2);
        chk(entire == m_ent, "R6 entire vs model", entire, m_ent);
        chk({set_i, set_f} == {m_si, m_sf}, "R7 masks vs model", {set_i, set_f}, {m_si, m_sf});
        chk(sync_resume == m_res, "R9 resume vs model", sync_resume, m_res);
        chk(rti_full == m_rf, "R10 restore vs model", rti_full, m_rf);
        chk(rti_go == m_rg, "R11 rti order vs model", rti_go, m_rg);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic finish_grant();
        boundary = 0; done = 1; cyc(); done = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            summary();
        end
    end

    initial begin
        cyc(); cyc();
        chk(take == 0, "R1 no grant in reset", take, 0);
        rst = 0; cyc();
        chk(take == 1 && vec_code == 3'b111 && vec_addr == 16'hFFFE, "R1 reset grant", vec_addr, 16'hFFFE);
        chk(set_i && set_f && !entire, "R1 reset masks", {set_i, set_f, entire}, 3'b110);
        finish_grant();

        // R4: edge before stack pointer load is forgotten
        nmi_in = 1; cyc(); nmi_in = 0; cyc();
        boundary = 1; cyc();
        chk(take == 0, "R4 nmi locked out", take, 0);
        boundary = 0; sp_loaded = 1; cyc(); sp_loaded = 0;
        boundary = 1; cyc();
        chk(take == 0, "R4 early edge not kept", take, 0);
        boundary = 0;

        // R5: one edge, held level
        nmi_in = 1; cyc(); cyc();
        boundary = 1; cyc();
        chk(take == 1 && vec_code == 3'b110, "R5 nmi granted", vec_code, 6);
        chk(entire == 1 && set_i && set_f, "R6 R7 nmi flags", {entire, set_i, set_f}, 3'b111);
        chk(vec_addr == 16'hFFFC, "R8 nmi address", vec_addr, 16'hFFFC);
        finish_grant();
        boundary = 1; cyc();
        chk(take == 0, "R5 held level no retrigger", take, 0);
        boundary = 0; nmi_in = 0; cyc();

        // R2: fast beats normal
        firq_in = 1; irq_in = 1; boundary = 1; cyc();
        chk(take == 1 && vec_code == 3'b011, "R2 fast over normal", vec_code, 3);
        chk(entire == 0 && vec_addr == 16'hFFF6, "R6 R8 fast grant", vec_addr, 16'hFFF6);
        cyc();
        chk(take == 0, "R13 no grant while serving", take, 0);
        finish_grant();

        // R3: masks
        mask_f = 1; boundary = 1; cyc();
        chk(take == 1 && vec_code == 3'b100, "R3 fast masked, normal taken", vec_code, 4);
        chk(set_i && !set_f && entire && vec_addr == 16'hFFF8, "R7 normal flags", {set_i, set_f, entire}, 3'b101);
        finish_grant();
        mask_i = 1; boundary = 1; cyc();
        chk(take == 0, "R3 both masked", take, 0);
        boundary = 0;

        // R2: all three together
        mask_f = 0; mask_i = 0; nmi_in = 1; cyc(); nmi_in = 0;
        boundary = 1; cyc();
        chk(take == 1 && vec_code == 3'b110, "R2 nmi over all", vec_code, 6);
        finish_grant();

        // R9: wait with masked requests
        mask_f = 1; mask_i = 1; sync_req = 1; cyc(); sync_req = 0; cyc();
        chk(sync_resume == 1 && take == 0, "R9 masked resume", sync_resume, 1);
        cyc();
        chk(sync_resume == 0, "R9 resume is one cycle", sync_resume, 0);

        // R9: wait then unmasked request
        firq_in = 0; irq_in = 0; mask_i = 0;
        sync_req = 1; cyc(); sync_req = 0; cyc();
        chk(take == 0, "R9 still waiting", take, 0);
        irq_in = 1; cyc();
        chk(take == 1 && vec_code == 3'b100, "R9 unmasked taken", vec_code, 4);
        finish_grant();
        irq_in = 0;

        // R10: restore decision from pulled bit, not from entire (currently 1)
        rti_pull = 1; rti_e = 0; cyc();
        chk(rti_full == 0, "R10 pulled bit clear", rti_full, 0);
        rti_e = 1; cyc();
        chk(rti_full == 1, "R10 pulled bit set", rti_full, 1);
        rti_pull = 0; rti_e = 0; cyc();
        chk(rti_full == 1, "R10 value kept", rti_full, 1);

        // R11
        bogus = 1; cyc(); bogus = 0;
        chk(rti_go == 1, "R11 error answer", rti_go, 1);
        cyc();
        chk(rti_go == 0, "R11 one cycle", rti_go, 0);

        // R12: hold
        irq_in = 1; boundary = 1; hold = 1; cyc();
        chk(take == 0, "R12 frozen under hold", take, 0);
        hold = 0; cyc();
        chk(take == 1, "R12 grant after hold", take, 1);
        hold = 1; boundary = 0; cyc(); cyc();
        chk(take == 1 && vec_code == 3'b100, "R12 grant held", take, 1);
        hold = 0; cyc();
        chk(take == 0, "R12 released", take, 0);
        irq_in = 0; finish_grant();
        cyc();

        summary();
    end
endmodule